// File: doc/BRIEF.md
# Timer Configuration Register Bank with Run-Time Write Lock

This block holds the configuration of a timer peripheral and serves it to the counter core as decoded fields. Software reaches it over a plain 32-bit register bus with a byte address, write data, per-byte strobes, a write enable and a combinational read-data return. There are four words. The control word carries the run bit, the soft-reset bit and the counter setup: width, clock division, division-restart policy and capture-channel selection. Three more words hold output inversion per channel, the waveform-generation selection and the event configuration.

While the timer runs, its setup is frozen. Only the run bit and the soft-reset bit respond to writes. Every other field keeps its value, and a blocked write leaves no trace. Within one write, the held run state decides what happens. A write that starts the timer may load new setup in the same access. A write that stops the timer changes only the run bit, so a new setup needs a second write. Soft reset returns the whole bank to its reset state, and its bit reads back as 1 for exactly one cycle.

Word offsets (byte address bits [3:2]): 0 = control, 1 = drive, 2 = waveform, 3 = event. Control word layout: bit 0 soft reset, bit 1 run, bits [3:2] counter width (00 = 16-bit, 01 = 8-bit, 10 = 32-bit), bits [10:8] clock divider, bits [13:12] restart policy, bits [17:16] capture enables. Drive word bits [1:0] are inversion enables. Waveform word bits [2:0] are the waveform selection. Event word bits [7:0] are the event configuration. All other bits read as 0.

Top module: `tmr_cfg_bank`

## Requirements
- R1: After reset every word reads 0, so the counter width field is 00 (16-bit counting) and the run bit is 0.
- R2: While the held run bit is 1, a control-word write leaves the width, divider, restart-policy and capture-enable fields unchanged.
- R3: While the held run bit is 1, writes to the drive, waveform and event words have no effect.
- R4: A single control write made while stopped that sets the run bit to 1 also loads every other control field it writes.
- R5: A single control write made while running that clears the run bit changes only the run bit. A later write made while stopped then changes the setup fields.
- R6: The run bit and the soft-reset bit can be written at any time, whatever the run state.
- R7: Writing 1 to control bit 0 (with strobe 0 set) clears every word to its reset value, run bit included. The soft-reset bit reads 1 during the next cycle and 0 after that.
- R8: A byte whose strobe is 0 keeps its previous contents, and the write lock is applied to each field after this masking.
- R9: Read data always shows the values currently held, and the configuration outputs always equal the corresponding read-back fields.
- R10: While stopped, every field of every word is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte write strobes |
| bus_we | input | 1 | Write enable; the write is taken at the clock edge |
| bus_rdata | output | 32 | Read data of the addressed word |
| cfg_run | output | 1 | Timer run bit |
| cfg_width | output | 2 | Counter width selection |
| cfg_prescale | output | 3 | Clock divider selection |
| cfg_presync | output | 2 | Divider restart policy |
| cfg_capten | output | 2 | Capture enables per channel |
| cfg_invert | output | 2 | Inversion enables per channel |
| cfg_wavegen | output | 3 | Waveform selection |
| cfg_event | output | 8 | Event configuration |

## Verification
The assertions assume that the bus inputs are free of X after reset and that they change only between clock edges. The bench drives every input to a known value from time zero and changes it just after a rising edge. The lock properties count a soft-reset write only when strobe 0 and data bit 0 are both set, so the bench issues soft resets only with that strobe set. When it wants to leave a byte alone, it clears that byte's strobe rather than relying on the data bits.

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank #(
  parameter int NCH    = 2,
  parameter int PS_W   = 3,
  parameter int SYNC_W = 2,
  parameter int WG_W   = 3,
  parameter int EV_W   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_strb,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              cfg_run,
  output logic [1:0]        cfg_width,
  output logic [PS_W-1:0]   cfg_prescale,
  output logic [SYNC_W-1:0] cfg_presync,
  output logic [NCH-1:0]    cfg_capten,
  output logic [NCH-1:0]    cfg_invert,
  output logic [WG_W-1:0]   cfg_wavegen,
  output logic [EV_W-1:0]   cfg_event
);
  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_DRV  = 2'd1;
  localparam logic [1:0] W_WAVE = 2'd2;
  localparam logic [1:0] W_EVT  = 2'd3;
  localparam int B_SRST = 0;
  localparam int B_RUN  = 1;
  localparam int B_WID  = 2;
  localparam int B_PS   = 8;
  localparam int B_SYNC = 12;
  localparam int B_CAP  = 16;

  logic              srst_q, run_q;
  logic [1:0]        wid_q;
  logic [PS_W-1:0]   ps_q;
  logic [SYNC_W-1:0] sync_q;
  logic [NCH-1:0]    cap_q, inv_q;
  logic [WG_W-1:0]   wg_q;
  logic [EV_W-1:0]   ev_q;

  logic [31:0] ctrl_rd, drv_rd, wave_rd, ev_rd;
  logic [31:0] bmask;
  logic [31:0] ctrl_nv, drv_nv, wave_nv, ev_nv;
  logic [1:0]  word;
  logic        open, srst_hit;

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[B_SRST]             = srst_q;
    ctrl_rd[B_RUN]              = run_q;
    ctrl_rd[B_WID +: 2]         = wid_q;
    ctrl_rd[B_PS +: PS_W]       = ps_q;
    ctrl_rd[B_SYNC +: SYNC_W]   = sync_q;
    ctrl_rd[B_CAP +: NCH]       = cap_q;
    drv_rd  = '0;
    drv_rd[NCH-1:0]  = inv_q;
    wave_rd = '0;
    wave_rd[WG_W-1:0] = wg_q;
    ev_rd   = '0;
    ev_rd[EV_W-1:0]  = ev_q;
  end

  genvar gb;
  generate
    for (gb = 0; gb < 4; gb++) begin : g_mask
      assign bmask[gb*8 +: 8] = {8{bus_strb[gb]}};
    end
  endgenerate

  assign word    = bus_addr[3:2];
  assign open    = !run_q;
  assign ctrl_nv = (ctrl_rd & ~bmask) | (bus_wdata & bmask);
  assign drv_nv  = (drv_rd  & ~bmask) | (bus_wdata & bmask);
  assign wave_nv = (wave_rd & ~bmask) | (bus_wdata & bmask);
  assign ev_nv   = (ev_rd   & ~bmask) | (bus_wdata & bmask);
  assign srst_hit = bus_we && word == W_CTRL && bus_strb[0] && bus_wdata[B_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      run_q  <= 1'b0;
      wid_q  <= '0;
      ps_q   <= '0;
      sync_q <= '0;
      cap_q  <= '0;
      inv_q  <= '0;
      wg_q   <= '0;
      ev_q   <= '0;
    end else if (srst_hit) begin
      srst_q <= 1'b1;
      run_q  <= 1'b0;
      wid_q  <= '0;
      ps_q   <= '0;
      sync_q <= '0;
      cap_q  <= '0;
      inv_q  <= '0;
      wg_q   <= '0;
      ev_q   <= '0;
    end else begin
      srst_q <= 1'b0;
      if (bus_we && word == W_CTRL) begin
        run_q <= ctrl_nv[B_RUN];
        if (open) begin
          wid_q  <= ctrl_nv[B_WID +: 2];
          ps_q   <= ctrl_nv[B_PS +: PS_W];
          sync_q <= ctrl_nv[B_SYNC +: SYNC_W];
          cap_q  <= ctrl_nv[B_CAP +: NCH];
        end
      end
      if (bus_we && open && word == W_DRV)  inv_q <= drv_nv[NCH-1:0];
      if (bus_we && open && word == W_WAVE) wg_q  <= wave_nv[WG_W-1:0];
      if (bus_we && open && word == W_EVT)  ev_q  <= ev_nv[EV_W-1:0];
    end
  end

  always_comb begin
    case (word)
      W_CTRL:  bus_rdata = ctrl_rd;
      W_DRV:   bus_rdata = drv_rd;
      W_WAVE:  bus_rdata = wave_rd;
      default: bus_rdata = ev_rd;
    endcase
  end

  assign cfg_run      = run_q;
  assign cfg_width    = wid_q;
  assign cfg_prescale = ps_q;
  assign cfg_presync  = sync_q;
  assign cfg_capten   = cap_q;
  assign cfg_invert   = inv_q;
  assign cfg_wavegen  = wg_q;
  assign cfg_event    = ev_q;
endmodule

// File: rtl/tmr_cfg_bank_chk.sv
module tmr_cfg_bank_chk #(
  parameter int NCH    = 2,
  parameter int PS_W   = 3,
  parameter int SYNC_W = 2,
  parameter int WG_W   = 3,
  parameter int EV_W   = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [3:0]        bus_strb,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              cfg_run,
  input logic [1:0]        cfg_width,
  input logic [PS_W-1:0]   cfg_prescale,
  input logic [SYNC_W-1:0] cfg_presync,
  input logic [NCH-1:0]    cfg_capten,
  input logic [NCH-1:0]    cfg_invert,
  input logic [WG_W-1:0]   cfg_wavegen,
  input logic [EV_W-1:0]   cfg_event,
  input logic              srst_q
);
  logic ctrl_wr, srst_w, start_w;
  assign ctrl_wr = bus_we && bus_addr[3:2] == 2'd0;
  assign srst_w  = ctrl_wr && bus_strb[0] && bus_wdata[0];
  assign start_w = ctrl_wr && bus_strb == 4'hF && bus_wdata[1] && !bus_wdata[0];

  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_run) && !$past(srst_w)) |->
      ($stable(cfg_width) && $stable(cfg_prescale) && $stable(cfg_presync) && $stable(cfg_capten))); // R2

  AST_AUX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_run) && !$past(srst_w)) |->
      ($stable(cfg_invert) && $stable(cfg_wavegen) && $stable(cfg_event))); // R3

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_w) && !$past(cfg_run)) |->
      (cfg_run && cfg_width == $past(bus_wdata[3:2]))); // R4

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst_w) |-> (!cfg_run && srst_q && cfg_width == 2'b00 && cfg_wavegen == '0 && cfg_event == '0)); // R7

  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !srst_w) |=> !srst_q); // R7

  AST_READ_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd0) |-> (bus_rdata[1] == cfg_run && bus_rdata[3:2] == cfg_width)); // R9
endmodule

bind tmr_cfg_bank tmr_cfg_bank_chk #(
  .NCH(NCH), .PS_W(PS_W), .SYNC_W(SYNC_W), .WG_W(WG_W), .EV_W(EV_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_strb(bus_strb), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .cfg_run(cfg_run), .cfg_width(cfg_width), .cfg_prescale(cfg_prescale),
  .cfg_presync(cfg_presync), .cfg_capten(cfg_capten), .cfg_invert(cfg_invert),
  .cfg_wavegen(cfg_wavegen), .cfg_event(cfg_event), .srst_q(srst_q)
);

// File: tb/tmr_cfg_bank_bench.sv
module tmr_cfg_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_strb = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        cfg_run;
  logic [1:0]  cfg_width;
  logic [2:0]  cfg_prescale;
  logic [1:0]  cfg_presync;
  logic [1:0]  cfg_capten;
  logic [1:0]  cfg_invert;
  logic [2:0]  cfg_wavegen;
  logic [7:0]  cfg_event;

  logic        rd_v = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tmr_cfg_bank u_tmr_cfg_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_strb(bus_strb), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .cfg_run(cfg_run), .cfg_width(cfg_width), .cfg_prescale(cfg_prescale),
    .cfg_presync(cfg_presync), .cfg_capten(cfg_capten), .cfg_invert(cfg_invert),
    .cfg_wavegen(cfg_wavegen), .cfg_event(cfg_event)
  );

  localparam logic [3:0] A_CTRL = 4'h0, A_DRV = 4'h4, A_WAVE = 4'h8, A_EVT = 4'hC;

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_strb = s; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_strb = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    bus_addr = a; rd_v = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_v = 1'b0;
  endtask

  task automatic see(input logic [31:0] act, input logic [31:0] e, input string tag);
    vectors++;
    if (act !== e) begin
      miscompares++;
      $display("FAIL %s output: got %h expected %h", tag, act, e);
    end
  endtask

  always @(negedge clk) begin
    if (rd_v && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (bus_rdata !== e) begin
        miscompares++;
        $display("FAIL %s readback addr %h: got %h expected %h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, 32'h0, "R1"); rd(A_DRV, 32'h0, "R1");
    rd(A_WAVE, 32'h0, "R1"); rd(A_EVT, 32'h0, "R1");
    see(32'(cfg_width), 32'h0, "R1");
    see(32'(cfg_run), 32'h0, "R1");
    // R10 all writable while stopped
    wr(A_CTRL, 32'h0003_2504, 4'hF);
    rd(A_CTRL, 32'h0003_2504, "R10");
    see(32'(cfg_prescale), 32'h5, "R9");
    see(32'(cfg_presync), 32'h2, "R9");
    wr(A_WAVE, 32'h5, 4'hF); rd(A_WAVE, 32'h5, "R10");
    wr(A_DRV, 32'h3, 4'hF);  rd(A_DRV, 32'h3, "R10");
    wr(A_EVT, 32'hA5, 4'hF); rd(A_EVT, 32'hA5, "R10");
    see(32'(cfg_event), 32'hA5, "R9");
    // R8 byte strobes
    wr(A_EVT, 32'hFF, 4'b1110); rd(A_EVT, 32'hA5, "R8");
    wr(A_CTRL, 32'h0, 4'b0010); rd(A_CTRL, 32'h0003_0004, "R8");
    // R4 start with new setup
    wr(A_CTRL, 32'h0001_030A, 4'hF);
    rd(A_CTRL, 32'h0001_030A, "R4");
    see(32'(cfg_run), 32'h1, "R4");
    see(32'(cfg_width), 32'h2, "R4");
    see(32'(cfg_capten), 32'h1, "R4");
    // R2 setup locked while running
    wr(A_CTRL, 32'h0000_0006, 4'hF);
    rd(A_CTRL, 32'h0001_030A, "R2");
    // R3 aux words locked
    wr(A_WAVE, 32'h2, 4'hF);  rd(A_WAVE, 32'h5, "R3");
    wr(A_DRV, 32'h0, 4'hF);   rd(A_DRV, 32'h3, "R3");
    wr(A_EVT, 32'h11, 4'hF);  rd(A_EVT, 32'hA5, "R3");
    see(32'(cfg_invert), 32'h3, "R3");
    // R5 stop write changes only run bit
    wr(A_CTRL, 32'h0000_0004, 4'hF);
    rd(A_CTRL, 32'h0001_0308, "R5");
    wr(A_CTRL, 32'h0000_0004, 4'hF);
    rd(A_CTRL, 32'h0000_0004, "R5");
    // R6 run bit via byte 0 only
    wr(A_CTRL, 32'hFFFF_FF06, 4'b0001);
    rd(A_CTRL, 32'h0000_0006, "R6");
    see(32'(cfg_run), 32'h1, "R6");
    // R7 soft reset while running
    wr(A_CTRL, 32'h0000_0001, 4'b0001);
    rd(A_CTRL, 32'h0000_0001, "R7");
    rd(A_CTRL, 32'h0000_0000, "R7");
    rd(A_WAVE, 32'h0, "R7"); rd(A_DRV, 32'h0, "R7"); rd(A_EVT, 32'h0, "R7");
    see(32'(cfg_run), 32'h0, "R7");
    // R10 writable again after soft reset
    wr(A_WAVE, 32'h6, 4'hF); rd(A_WAVE, 32'h6, "R10");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule